// File: doc/BRIEF.md
# Branch Hazard Pipeline Controller

This block is the control-flow steering logic of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it looks at which pipeline stages hold a valid conditional branch. It also takes the branch outcome and target from the stage that resolves branches, and a stall request raised elsewhere for data hazards. From these it chooses the next-PC source and drives hold and flush strobes for the fetch/decode, decode/execute and execute/memory pipeline registers. A flushed register is expected to become a bubble: the pipeline clears its valid bit and its register-write and memory-write enables.

A build-time parameter selects one of four branch policies:

- Policy 0 stalls fetch until the branch resolves in the memory stage.
- Policy 1 keeps fetching the fall-through path. When a branch resolves taken in the memory stage, the three younger instructions are squashed.
- Policy 2 resolves branches in decode. A taken branch costs one flushed slot.
- Policy 3 resolves in decode and has one architectural delay slot, so nothing is ever flushed.

A running counter reports the total number of fetch slots lost to branches, so the cost per branch can be observed for each policy.

The decision logic is combinational from the current stage flags. The only state is the penalty counter. In policies 0 and 1, `br_taken` and `br_target` belong to the branch in the memory stage. In policies 2 and 3, they belong to the branch in decode.

Top module: `branch_hazard_ctrl`

## Requirements
- R1: After a synchronous active-low reset the penalty counter reads 0. With no valid branch and no stall request, `pc_sel` is 0 (sequential; the encoding is 0 sequential, 1 hold, 2 redirect) and every hold and flush strobe is low.
- R2: Under policy 0 the controller reacts in each cycle that a valid branch sits in decode, execute or memory (memory taking precedence over execute, and execute over decode). In each such cycle it asserts `flush_ifid` and sets `pc_sel` to 1. The exception is a taken branch in memory, which gives `pc_sel` 2. Each branch adds exactly 3 to the counter, taken or not.
- R3: Under policy 1 a valid taken branch in memory gives `pc_sel` 2 and asserts `flush_ifid`, `flush_idex` and `flush_exmem` together. The counter grows by 3.
- R4: Under policy 1 a not-taken branch, or a branch still in decode or execute, leaves `pc_sel` at 0, raises no flush and adds nothing to the counter.
- R5: Under policy 2 a valid taken branch in decode gives `pc_sel` 2 and flushes only `flush_ifid`. The counter grows by 1. A not-taken branch adds 0 and flushes nothing.
- R6: Under policy 3 a valid taken branch in decode gives `pc_sel` 2 with no flush strobe at all. The counter is unchanged for taken and not-taken branches.
- R7: `redirect_pc` equals `br_target` whenever `pc_sel` is 2 and is zero otherwise.
- R8: A stall request with no redirect and no branch stall of higher precedence gives `pc_sel` 1 and asserts `hold_ifid` and `flush_idex`. It adds nothing to the counter.
- R9: A redirect takes priority over a simultaneous stall request: `pc_sel` is 2 and `hold_ifid` is low.
- R10: A stage whose branch flag is set while its valid flag is low is ignored. All outputs stay idle and the counter is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Decode stage holds a valid instruction |
| id_is_br | input | 1 | Decode stage instruction is a conditional branch |
| ex_valid | input | 1 | Execute stage holds a valid instruction |
| ex_is_br | input | 1 | Execute stage instruction is a conditional branch |
| mem_valid | input | 1 | Memory stage holds a valid instruction |
| mem_is_br | input | 1 | Memory stage instruction is a conditional branch |
| br_taken | input | 1 | Outcome of the branch in the resolving stage |
| br_target | input | AW | Computed target of that branch |
| hz_stall_req | input | 1 | Data-hazard stall request from elsewhere |
| pc_sel | output | 2 | Next-PC source: 0 sequential, 1 hold, 2 redirect |
| redirect_pc | output | AW | Redirect address, zero when not redirecting |
| hold_ifid | output | 1 | Keep the fetch/decode register contents |
| flush_ifid | output | 1 | Load a bubble into the fetch/decode register |
| flush_idex | output | 1 | Load a bubble into the decode/execute register |
| flush_exmem | output | 1 | Load a bubble into the execute/memory register |
| penalty_cnt | output | CW | Total fetch slots lost to branches |

## Verification
A wrong choice of next-PC source or flush set appears in the same cycle, because every steering output is combinational from the stage flags. A squash missing one register would let a wrong-path instruction reach a stage that changes state. A wrong penalty contribution shows on `penalty_cnt` one edge later. Because the bench walks each branch through decode, execute and memory, the counter difference after one branch exposes an error in any cycle of the window. Priority mistakes between redirect, branch stall and data stall are exposed by cycles where more than one condition is raised.

// File: rtl/bhz_pkg.sv
// Shared encodings for the branch hazard controller.
// Assumes stage indices are ordered oldest-last: decode, execute, memory.
package bhz_pkg;
    typedef enum logic [1:0] {
        PCS_SEQ   = 2'd0,
        PCS_HOLD  = 2'd1,
        PCS_REDIR = 2'd2
    } pcsel_e;

    localparam int POL_STALL  = 0;
    localparam int POL_SQUASH = 1;
    localparam int POL_EARLY  = 2;
    localparam int POL_DSLOT  = 3;

    localparam int N_STAGES = 3;
    localparam int STG_ID   = 0;
    localparam int STG_EX   = 1;
    localparam int STG_MEM  = 2;

    localparam int KILL_W = 2;
endpackage

// File: rtl/bhz_stage_flags.sv
// Qualifies per-stage branch flags with the stage valid bits.
// Assumes a flag is meaningful only while its stage holds a valid instruction.
module bhz_stage_flags #(
    parameter int NSTG = 3
) (
    input  logic [NSTG-1:0] stg_valid,
    input  logic [NSTG-1:0] stg_is_br,
    output logic [NSTG-1:0] br_hit
);
    // One qualifier per stage.
    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        assign br_hit[s] = stg_valid[s] & stg_is_br[s];
    end
endmodule

// File: rtl/bhz_policy.sv
// Branch policy decision unit: picks redirect, hold and flush actions
// and the number of fetch slots lost this cycle.
// Assumes br_taken belongs to the branch in the resolving stage
// (memory for policies 0/1, decode for policies 2/3).
module bhz_policy
    import bhz_pkg::*;
#(
    parameter int POLICY = POL_SQUASH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_STAGES-1:0] br_hit,
    input  logic                br_taken,
    input  logic                hz_stall_req,
    output logic                redirect,
    output logic                pc_hold,
    output logic                hold_ifid,
    output logic                fl_ifid,
    output logic                fl_idex,
    output logic                fl_exmem,
    output logic [KILL_W-1:0]   kill_n
);
    localparam bit IS_STALL  = (POLICY == POL_STALL);
    localparam bit IS_SQUASH = (POLICY == POL_SQUASH);
    localparam bit IS_EARLY  = (POLICY == POL_EARLY);
    localparam bit IS_DSLOT  = (POLICY == POL_DSLOT);

    logic hit_id, hit_ex, hit_mem;
    assign hit_id  = br_hit[STG_ID];
    assign hit_ex  = br_hit[STG_EX];
    assign hit_mem = br_hit[STG_MEM];

    // Per-cycle action selection in priority order for the chosen policy.
    always_comb begin
        redirect  = 1'b0;
        pc_hold   = 1'b0;
        hold_ifid = 1'b0;
        fl_ifid   = 1'b0;
        fl_idex   = 1'b0;
        fl_exmem  = 1'b0;
        kill_n    = '0;
        if (IS_STALL) begin
            if (hit_mem) begin
                fl_ifid = 1'b1;
                kill_n  = KILL_W'(1);
                if (br_taken) redirect = 1'b1;
                else          pc_hold  = 1'b1;
            end else if (hit_ex) begin
                fl_ifid = 1'b1;
                pc_hold = 1'b1;
                kill_n  = KILL_W'(1);
            end else if (hz_stall_req) begin
                pc_hold   = 1'b1;
                hold_ifid = 1'b1;
                fl_idex   = 1'b1;
            end else if (hit_id) begin
                fl_ifid = 1'b1;
                pc_hold = 1'b1;
                kill_n  = KILL_W'(1);
            end
        end else if (IS_SQUASH) begin
            if (hit_mem && br_taken) begin
                redirect = 1'b1;
                fl_ifid  = 1'b1;
                fl_idex  = 1'b1;
                fl_exmem = 1'b1;
                kill_n   = KILL_W'(3);
            end else if (hz_stall_req) begin
                pc_hold   = 1'b1;
                hold_ifid = 1'b1;
                fl_idex   = 1'b1;
            end
        end else begin
            if (hit_id && br_taken) begin
                redirect = 1'b1;
                fl_ifid  = IS_EARLY;
                kill_n   = IS_EARLY ? KILL_W'(1) : '0;
            end else if (hz_stall_req) begin
                pc_hold   = 1'b1;
                hold_ifid = 1'b1;
                fl_idex   = 1'b1;
            end
        end
    end

    AST_SQUASH_ALL3: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_SQUASH && redirect) |-> (fl_ifid && fl_idex && fl_exmem)); // R3
    AST_EARLY_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (IS_EARLY && redirect) |-> (fl_ifid && !fl_idex && !fl_exmem)); // R5
    AST_DSLOT_NO_KILL: assert property (@(posedge clk) disable iff (!rst_n)
        IS_DSLOT |-> (!fl_ifid && !fl_exmem && kill_n == '0)); // R6
endmodule

// File: rtl/bhz_pen_ctr.sv
// Accumulates fetch slots lost to branch handling.
// Assumes at most three slots are lost in any one cycle.
module bhz_pen_ctr
    import bhz_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [KILL_W-1:0] kill_n,
    output logic [CW-1:0]     cnt
);
    // Add this cycle's lost slots, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + CW'(kill_n);
    end

    AST_PEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (CW'(cnt - $past(cnt)) <= CW'(3))); // R2
    AST_PEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (kill_n == '0) |=> $stable(cnt)); // R8
endmodule

// File: rtl/branch_hazard_ctrl.sv
// Top of the branch hazard controller: qualifies stage flags, applies the
// selected branch policy, encodes the next-PC source and counts penalty.
// Assumes the surrounding pipeline applies hold/flush on the next edge.
module branch_hazard_ctrl
    import bhz_pkg::*;
#(
    parameter int POLICY = POL_SQUASH,
    parameter int AW     = 32,
    parameter int CW     = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          id_valid,
    input  logic          id_is_br,
    input  logic          ex_valid,
    input  logic          ex_is_br,
    input  logic          mem_valid,
    input  logic          mem_is_br,
    input  logic          br_taken,
    input  logic [AW-1:0] br_target,
    input  logic          hz_stall_req,
    output logic [1:0]    pc_sel,
    output logic [AW-1:0] redirect_pc,
    output logic          hold_ifid,
    output logic          flush_ifid,
    output logic          flush_idex,
    output logic          flush_exmem,
    output logic [CW-1:0] penalty_cnt
);
    logic [N_STAGES-1:0] stg_valid, stg_is_br, br_hit;
    logic                redirect, pc_hold;
    logic [KILL_W-1:0]   kill_n;
    pcsel_e              sel;

    assign stg_valid = {mem_valid, ex_valid, id_valid};
    assign stg_is_br = {mem_is_br, ex_is_br, id_is_br};

    bhz_stage_flags #(.NSTG(N_STAGES)) u_flags (
        .stg_valid (stg_valid),
        .stg_is_br (stg_is_br),
        .br_hit    (br_hit)
    );

    bhz_policy #(.POLICY(POLICY)) u_pol (
        .clk          (clk),
        .rst_n        (rst_n),
        .br_hit       (br_hit),
        .br_taken     (br_taken),
        .hz_stall_req (hz_stall_req),
        .redirect     (redirect),
        .pc_hold      (pc_hold),
        .hold_ifid    (hold_ifid),
        .fl_ifid      (flush_ifid),
        .fl_idex      (flush_idex),
        .fl_exmem     (flush_exmem),
        .kill_n       (kill_n)
    );

    bhz_pen_ctr #(.CW(CW)) u_pen (
        .clk   (clk),
        .rst_n (rst_n),
        .kill_n(kill_n),
        .cnt   (penalty_cnt)
    );

    // Encode the next-PC source: redirect over hold over sequential.
    always_comb begin
        if (redirect)     sel = PCS_REDIR;
        else if (pc_hold) sel = PCS_HOLD;
        else              sel = PCS_SEQ;
    end

    assign pc_sel      = sel;
    assign redirect_pc = redirect ? br_target : '0;

    AST_REDIR_BEATS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd2) |-> !hold_ifid); // R9
    AST_TARGET_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel != 2'd2) |-> (redirect_pc == '0)); // R7
    AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        pc_sel != 2'd3); // R1
endmodule

// File: tb/sim_branch_hazard_ctrl.sv
module sim_branch_hazard_ctrl;
    localparam int AW = 32;
    localparam int CW = 16;
    localparam int NP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic id_valid, id_is_br, ex_valid, ex_is_br, mem_valid, mem_is_br;
    logic br_taken, hz_stall_req;
    logic [AW-1:0] br_target;

    logic [1:0]    psel [NP];
    logic [AW-1:0] rpc  [NP];
    logic          hld  [NP];
    logic          fi   [NP];
    logic          fd   [NP];
    logic          fe   [NP];
    logic [CW-1:0] pen  [NP];

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    for (genvar g = 0; g < NP; g++) begin : g_pol
        branch_hazard_ctrl #(.POLICY(g), .AW(AW), .CW(CW)) u0 (
            .clk(clk), .rst_n(rst_n),
            .id_valid(id_valid), .id_is_br(id_is_br),
            .ex_valid(ex_valid), .ex_is_br(ex_is_br),
            .mem_valid(mem_valid), .mem_is_br(mem_is_br),
            .br_taken(br_taken), .br_target(br_target),
            .hz_stall_req(hz_stall_req),
            .pc_sel(psel[g]), .redirect_pc(rpc[g]), .hold_ifid(hld[g]),
            .flush_ifid(fi[g]), .flush_idex(fd[g]), .flush_exmem(fe[g]),
            .penalty_cnt(pen[g])
        );
    end

    task automatic chk(input string req, input string what, input int p,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s policy%0d %s act=%0h exp=%0h", req, p, what, act, exp);
        end
    endtask

    // Check every steering output of one policy instance.
    task automatic expect_out(input string req, input int p, input logic [1:0] ps,
                              input logic h, input logic a, input logic b, input logic c);
        chk(req, "pc_sel", p, 64'(psel[p]), 64'(ps));
        chk(req, "hold_ifid", p, 64'(hld[p]), 64'(h));
        chk(req, "flush_ifid", p, 64'(fi[p]), 64'(a));
        chk(req, "flush_idex", p, 64'(fd[p]), 64'(b));
        chk(req, "flush_exmem", p, 64'(fe[p]), 64'(c));
        chk("R7", "redirect_pc", p, 64'(rpc[p]), (ps == 2'd2) ? 64'(br_target) : 64'd0);
    endtask

    task automatic drive_idle();
        id_valid = 1'b1; id_is_br = 1'b0;
        ex_valid = 1'b1; ex_is_br = 1'b0;
        mem_valid = 1'b1; mem_is_br = 1'b0;
        br_taken = 1'b0; hz_stall_req = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk); drive_idle(); #1;
        for (int p = 0; p < NP; p++) begin
            chk("R1", "penalty_cnt", p, 64'(pen[p]), 64'd0);
            expect_out("R1", p, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        end
    endtask

    // Walk one branch through decode, execute and memory.
    task automatic t_branch(input logic tk, input logic [AW-1:0] tgt);
        logic [CW-1:0] base [NP];
        logic [1:0] mem_sel;
        for (int p = 0; p < NP; p++) base[p] = pen[p];
        mem_sel = tk ? 2'd2 : 2'd1;
        // branch in decode
        @(negedge clk); drive_idle(); id_is_br = 1'b1; br_taken = tk; br_target = tgt; #1;
        expect_out("R2", 0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R4", 1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R5", 2, tk ? 2'd2 : 2'd0, 1'b0, tk, 1'b0, 1'b0);
        expect_out("R6", 3, tk ? 2'd2 : 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        // branch in execute
        @(negedge clk); drive_idle(); ex_is_br = 1'b1; br_taken = tk; #1;
        expect_out("R2", 0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R4", 1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        // branch in memory
        @(negedge clk); drive_idle(); mem_is_br = 1'b1; br_taken = tk; #1;
        expect_out("R2", 0, mem_sel, 1'b0, 1'b1, 1'b0, 1'b0);
        if (tk) expect_out("R3", 1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1);
        else    expect_out("R4", 1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R5", 2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R6", 3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        // penalty after the branch has left the window
        @(negedge clk); drive_idle(); #1;
        chk("R2", "penalty delta", 0, 64'(CW'(pen[0] - base[0])), 64'd3);
        chk(tk ? "R3" : "R4", "penalty delta", 1, 64'(CW'(pen[1] - base[1])), tk ? 64'd3 : 64'd0);
        chk("R5", "penalty delta", 2, 64'(CW'(pen[2] - base[2])), tk ? 64'd1 : 64'd0);
        chk("R6", "penalty delta", 3, 64'(CW'(pen[3] - base[3])), 64'd0);
    endtask

    task automatic t_hz_stall();
        logic [CW-1:0] base [NP];
        for (int p = 0; p < NP; p++) base[p] = pen[p];
        @(negedge clk); drive_idle(); hz_stall_req = 1'b1; #1;
        for (int p = 0; p < NP; p++) expect_out("R8", p, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
        @(negedge clk); drive_idle(); #1;
        for (int p = 0; p < NP; p++)
            chk("R8", "penalty unchanged", p, 64'(pen[p]), 64'(base[p]));
    endtask

    task automatic t_priority();
        // taken branch in decode plus stall request
        @(negedge clk); drive_idle(); id_is_br = 1'b1; br_taken = 1'b1;
        br_target = 32'h0000_7F10; hz_stall_req = 1'b1; #1;
        expect_out("R9", 2, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R9", 3, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out("R8", 0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
        expect_out("R8", 1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0);
        // taken branch in memory plus stall request
        @(negedge clk); drive_idle(); mem_is_br = 1'b1; br_taken = 1'b1;
        br_target = 32'h0000_0C44; hz_stall_req = 1'b1; #1;
        expect_out("R9", 0, 2'd2, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out("R9", 1, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1);
        @(negedge clk); drive_idle(); #1;
    endtask

    task automatic t_invalid();
        logic [CW-1:0] base [NP];
        for (int p = 0; p < NP; p++) base[p] = pen[p];
        @(negedge clk);
        id_valid = 1'b0; id_is_br = 1'b1;
        ex_valid = 1'b0; ex_is_br = 1'b1;
        mem_valid = 1'b0; mem_is_br = 1'b1;
        br_taken = 1'b1; hz_stall_req = 1'b0; br_target = 32'h0000_1234; #1;
        for (int p = 0; p < NP; p++) expect_out("R10", p, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk); drive_idle(); #1;
        for (int p = 0; p < NP; p++)
            chk("R10", "penalty unchanged", p, 64'(pen[p]), 64'(base[p]));
    endtask

    task automatic t_mid_reset();
        @(negedge clk); drive_idle(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        t_reset();
    endtask

    initial begin
        drive_idle();
        br_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_branch(1'b1, 32'h0000_4A60);
        t_branch(1'b0, 32'h0000_2200);
        t_branch(1'b1, 32'hFFFF_FFFC);
        t_hz_stall();
        t_priority();
        t_invalid();
        t_branch(1'b0, 32'h8000_0000);
        t_mid_reset();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule